// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end and embedded write engine of a byte-wide flash memory that is erased one block at a time. A host reaches it over a plain SRAM-style bus (chip enable, write enable, output enable, address, data in, data out). Every write is taken as a command. Programming a byte, or erasing a block, takes two writes: a setup code, then a second write that carries the data or the confirm code. After that the engine finishes the job by itself, including a verify pass. Cycle counters stand in for the real program and erase times.

A status byte shows whether the engine is idle, whether an erase is on hold, and which errors have happened since the last clear. A ready output goes low while a job runs. An erase can be put on hold so the host can read other blocks, then resumed. A power-down input resets the engine and clears status. When it is released, reads become valid after one delay and commands are accepted after a second, longer delay. A programming-supply-good input blocks program and erase jobs when the supply is not valid. The array holds a parameterised number of equal blocks, sixteen by default.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The write pair 0x40, then data D at address A, stores (old byte AND D) at A. `ready` is low for exactly PROG_CYC+1 cycles after the clock edge that takes the data write.
- R2: The write pair 0x20, then 0xD0 at any address in block N, sets every byte of block N to 0xFF and leaves the other blocks unchanged. `ready` is low for exactly ERASE_CYC+2*BLOCK_BYTES cycles after the confirm edge.
- R3: The status byte has these fields: bit7 = engine ready, bit6 = erase on hold, bit5 = erase error, bit4 = program error, bit3 = supply low, bits 2..0 = 0. Code 0x70 selects status reads and 0xFF selects array reads.
- R4: While a job runs, every read returns the status byte, whatever the read mode. `ready` is low only while a job runs.
- R5: An erase setup followed by any value other than 0xD0 sets status bits 5 and 4, starts no erase, and leaves the array unchanged.
- R6: If `vpp_ok` is low at the second write, the array is not changed and the engine stays ready. Status bit3 is set, together with bit4 for a program or bit5 for an erase.
- R7: Error bits 5..3 stay set until a 0x50 write clears them.
- R8: The code 0xB0, written during an erase, puts the erase on hold at that edge: `ready` goes high and status bits 7 and 6 are set. Reads of other blocks then work. The code 0xD0 resumes the erase, and it runs to completion.
- R9: While `pwrdn_n` is low, `ready` is high, `dout` is 0x00, writes are ignored, and the engine state, status bits and read mode are reset.
- R10: After `pwrdn_n` rises, array reads are valid from READ_DLY edges onward. A command is accepted only at or after the WAKE_DLY-th edge; a write taken at an earlier edge has no effect.
- R11: Codes that are not defined, and any write other than 0xB0 (during an erase) made while a job runs, are ignored.
- R12: `dout` is 0x00 whenever `ce_n` or `oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| pwrdn_n | input | 1 | Power-down / engine reset, active low |
| vpp_ok | input | 1 | Programming supply is valid |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; one command per sampled cycle |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the upper bits select the block |
| din | input | 8 | Command or data byte |
| dout | output | 8 | Read data: array byte or status byte |
| ready | output | 1 | High when the engine is idle, an erase is on hold, or power is down |

## Verification
A write counts at the first rising edge where it is held. Mode changes, holds and error flags show on the next read, because reads are combinational and take no edge. After a data write, `ready` is sampled low after PROG_CYC edges and high after PROG_CYC+1 edges. After an erase confirm it is sampled low after ERASE_CYC+2*BLOCK_BYTES-1 edges and high one edge later. After `pwrdn_n` rises, a read taken after READ_DLY-1 edges must still return zero and a read taken after READ_DLY edges must return array data. A status-mode write taken at edge WAKE_DLY-1 must be ignored and one taken at edge WAKE_DLY must be accepted. The bench drives on falling edges and samples shortly after them, so each check falls at a known edge count.

// File: rtl/flash_cmd_pkg.sv
// Package: command codes, read modes and engine states shared by the
// flash command controller. Assumes a byte-wide data bus.
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;

    typedef enum logic {RD_ARRAY, RD_STATUS} read_mode_e;

    typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE} pend_e;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_PROG, ENG_PVFY, ENG_EWAIT, ENG_ESWEEP, ENG_EVFY
    } eng_state_e;

endpackage

// File: rtl/fcc_wake_timer.sv
// Recovery timer: counts clock edges after power-down release and opens
// the read path after READ_DLY edges and the command path after WAKE_DLY.
// Assumes WAKE_DLY >= READ_DLY.
module fcc_wake_timer #(
    parameter int READ_DLY = 3,
    parameter int WAKE_DLY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    output logic read_ok,
    output logic cmd_ok
);
    localparam int CNT_W = $clog2(WAKE_DLY + 1);
    localparam logic [CNT_W-1:0] READ_LIM = CNT_W'(READ_DLY);
    localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_DLY);

    logic [CNT_W-1:0] cnt;

    // Saturating count of edges since reset and power-down are released.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            cnt <= '0;
        end else if (cnt != WAKE_LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Gate flags derived from the count.
    always_comb begin
        read_ok = pwrdn_n && (cnt >= READ_LIM);
        cmd_ok  = pwrdn_n && (cnt >= WAKE_LIM);
    end
endmodule

// File: rtl/fcc_cmd_decode.sv
// Command decoder: turns host writes into read-mode changes and one-cycle
// job requests for the engine. It tracks the setup half of the two-write
// sequences and checks the supply at the second write. Assumes wr_en is
// already qualified by the wake timer.
module fcc_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrdn_n,
    input  logic       wr_en,
    input  logic [7:0] din,
    input  logic       vpp_ok,
    input  logic       eng_running,
    input  logic       eng_erasing,
    input  logic       eng_susp,
    output logic       rd_status,
    output logic       start_prog,
    output logic       start_erase,
    output logic       do_suspend,
    output logic       do_resume,
    output logic       do_clear,
    output logic       set_werr,
    output logic       set_eerr,
    output logic       set_vpp
);
    read_mode_e mode, mode_n;
    pend_e      pend, pend_n;

    // Next-state and request pulses for one host write.
    always_comb begin
        mode_n      = mode;
        pend_n      = pend;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        do_suspend  = 1'b0;
        do_resume   = 1'b0;
        do_clear    = 1'b0;
        set_werr    = 1'b0;
        set_eerr    = 1'b0;
        set_vpp     = 1'b0;
        if (wr_en) begin
            if (eng_running) begin
                if (eng_erasing && din == CMD_SUSPEND) begin
                    do_suspend = 1'b1;
                    mode_n     = RD_STATUS;
                end
            end else if (pend == PEND_PROG) begin
                pend_n = PEND_NONE;
                mode_n = RD_STATUS;
                if (vpp_ok) begin
                    start_prog = 1'b1;
                end else begin
                    set_werr = 1'b1;
                    set_vpp  = 1'b1;
                end
            end else if (pend == PEND_ERASE) begin
                pend_n = PEND_NONE;
                mode_n = RD_STATUS;
                if (din != CMD_CONFIRM) begin
                    set_werr = 1'b1;
                    set_eerr = 1'b1;
                end else if (vpp_ok) begin
                    start_erase = 1'b1;
                end else begin
                    set_eerr = 1'b1;
                    set_vpp  = 1'b1;
                end
            end else begin
                case (din)
                    CMD_READ_ARRAY:   mode_n = RD_ARRAY;
                    CMD_READ_STATUS:  mode_n = RD_STATUS;
                    CMD_CLEAR_STATUS: do_clear = 1'b1;
                    CMD_PROG_SETUP: begin
                        if (!eng_susp) begin
                            pend_n = PEND_PROG;
                            mode_n = RD_STATUS;
                        end
                    end
                    CMD_ERASE_SETUP: begin
                        if (!eng_susp) begin
                            pend_n = PEND_ERASE;
                            mode_n = RD_STATUS;
                        end
                    end
                    CMD_CONFIRM: begin
                        if (eng_susp) begin
                            do_resume = 1'b1;
                            mode_n    = RD_STATUS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register read mode and pending setup; power-down returns to array reads.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            mode <= RD_ARRAY;
            pend <= PEND_NONE;
        end else begin
            mode <= mode_n;
            pend <= pend_n;
        end
    end

    assign rd_status = (mode == RD_STATUS);
endmodule

// File: rtl/fcc_engine.sv
// Write engine: runs byte program (timed wait, write, verify) and block
// erase (timed wait, sweep to 0xFF, verify sweep) on its own once
// started. It can hold an erase and resume it, and keeps the error flags.
// Assumes the array read port it drives returns data in the same cycle.
module fcc_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 4,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              do_suspend,
    input  logic              do_resume,
    input  logic              do_clear,
    input  logic              set_werr,
    input  logic              set_eerr,
    input  logic              set_vpp,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    output logic              running,
    output logic              erasing,
    output logic              susp,
    output logic [2:0]        err_flags
);
    localparam int BLK_W = ADDR_W - IDX_W;
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = '1;

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BLK_W-1:0]  tgt_blk;
    logic [7:0]        tgt_data;
    logic [7:0]        exp_byte;
    logic              eerr, werr, vlow;
    logic              live;

    // Engine is not in reset.
    assign live = rst_n && pwrdn_n;

    // Array address and write request for the current step.
    always_comb begin
        arr_addr  = tgt_addr;
        arr_we    = 1'b0;
        arr_wdata = arr_rdata & tgt_data;
        if (state == ENG_ESWEEP || state == ENG_EVFY) begin
            arr_addr = {tgt_blk, idx};
        end
        if (live && !susp) begin
            if (state == ENG_PROG && cnt == PROG_LAST) begin
                arr_we = 1'b1;
            end
            if (state == ENG_ESWEEP) begin
                arr_we    = 1'b1;
                arr_wdata = 8'hFF;
            end
        end
    end

    // Sequencer for program/erase jobs, including hold and resume.
    always_ff @(posedge clk) begin
        if (!live) begin
            state    <= ENG_IDLE;
            susp     <= 1'b0;
            cnt      <= '0;
            idx      <= '0;
            tgt_addr <= '0;
            tgt_blk  <= '0;
            tgt_data <= 8'hFF;
            exp_byte <= 8'hFF;
        end else if (susp) begin
            if (do_resume) begin
                susp <= 1'b0;
            end
        end else begin
            case (state)
                ENG_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                    if (start_prog) begin
                        state    <= ENG_PROG;
                        tgt_addr <= cmd_addr;
                        tgt_data <= cmd_data;
                    end else if (start_erase) begin
                        state   <= ENG_EWAIT;
                        tgt_blk <= cmd_addr[ADDR_W-1:IDX_W];
                    end
                end
                ENG_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state    <= ENG_PVFY;
                        exp_byte <= arr_wdata;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_PVFY: state <= ENG_IDLE;
                ENG_EWAIT: begin
                    if (do_suspend) begin
                        susp <= 1'b1;
                    end else if (cnt == ERASE_LAST) begin
                        state <= ENG_ESWEEP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_ESWEEP: begin
                    if (do_suspend) begin
                        susp <= 1'b1;
                    end else if (idx == IDX_LAST) begin
                        state <= ENG_EVFY;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ENG_EVFY: begin
                    if (do_suspend) begin
                        susp <= 1'b1;
                    end else if (idx == IDX_LAST) begin
                        state <= ENG_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Sticky error flags: clear on command, set by decoder or verify.
    always_ff @(posedge clk) begin
        if (!live) begin
            eerr <= 1'b0;
            werr <= 1'b0;
            vlow <= 1'b0;
        end else begin
            eerr <= (eerr && !do_clear) || set_eerr ||
                    (!susp && state == ENG_EVFY && !do_suspend && arr_rdata != 8'hFF);
            werr <= (werr && !do_clear) || set_werr ||
                    (state == ENG_PVFY && arr_rdata != exp_byte);
            vlow <= (vlow && !do_clear) || set_vpp;
        end
    end

    // Status outputs for the top level.
    always_comb begin
        erasing   = (state == ENG_EWAIT) || (state == ENG_ESWEEP) || (state == ENG_EVFY);
        running   = (state != ENG_IDLE) && !susp;
        err_flags = {eerr, werr, vlow};
    end
endmodule

// File: rtl/fcc_array.sv
// Byte array with one synchronous write port and two combinational read
// ports (host side and engine side). Contents are non-volatile: no reset.
module fcc_array #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    logic [7:0] mem [DEPTH];

    // Store one byte per write request.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read ports.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top level of the flash command controller: host bus gating, wake timer,
// command decoder, write engine and array. Assumes one command per cycle
// in which ce_n and we_n are both low at a rising edge.
module flash_cmd_ctrl #(
    parameter int BLOCKS      = 16,
    parameter int BLOCK_BYTES = 16,
    parameter int PROG_CYC    = 4,
    parameter int ERASE_CYC   = 8,
    parameter int READ_DLY    = 3,
    parameter int WAKE_DLY    = 10,
    localparam int DEPTH      = BLOCKS * BLOCK_BYTES,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              vpp_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              ready
);
    localparam int IDX_W = $clog2(BLOCK_BYTES);

    logic              read_ok, cmd_ok, wr_en, rd_status;
    logic              start_prog, start_erase, do_suspend, do_resume, do_clear;
    logic              set_werr, set_eerr, set_vpp;
    logic              running, erasing, eng_susp;
    logic [2:0]        err_flags;
    logic [ADDR_W-1:0] eng_addr;
    logic              arr_we;
    logic [7:0]        arr_wdata, host_rdata, eng_rdata, status_byte;

    // Qualified host write strobe.
    assign wr_en = !ce_n && !we_n && cmd_ok;

    fcc_wake_timer #(.READ_DLY(READ_DLY), .WAKE_DLY(WAKE_DLY)) u_wake (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
        .read_ok(read_ok), .cmd_ok(cmd_ok)
    );

    fcc_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .wr_en(wr_en), .din(din),
        .vpp_ok(vpp_ok), .eng_running(running), .eng_erasing(erasing),
        .eng_susp(eng_susp), .rd_status(rd_status), .start_prog(start_prog),
        .start_erase(start_erase), .do_suspend(do_suspend), .do_resume(do_resume),
        .do_clear(do_clear), .set_werr(set_werr), .set_eerr(set_eerr),
        .set_vpp(set_vpp)
    );

    fcc_engine #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .start_prog(start_prog),
        .start_erase(start_erase), .do_suspend(do_suspend), .do_resume(do_resume),
        .do_clear(do_clear), .set_werr(set_werr), .set_eerr(set_eerr),
        .set_vpp(set_vpp), .cmd_addr(addr), .cmd_data(din), .arr_rdata(eng_rdata),
        .arr_addr(eng_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
        .running(running), .erasing(erasing), .susp(eng_susp), .err_flags(err_flags)
    );

    fcc_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(arr_we), .waddr(eng_addr), .wdata(arr_wdata),
        .raddr_a(addr), .rdata_a(host_rdata), .raddr_b(eng_addr), .rdata_b(eng_rdata)
    );

    // Read mux: status while busy or in status mode, else array data.
    always_comb begin
        status_byte = {!running, eng_susp, err_flags, 3'b000};
        if (ce_n || oe_n || !read_ok) begin
            dout = 8'h00;
        end else if (running || rd_status) begin
            dout = status_byte;
        end else begin
            dout = host_rdata;
        end
        ready = !running || !pwrdn_n;
    end
endmodule

// File: rtl/fcc_checker.sv
// Checker for the flash command controller, bound to the top level.
module fcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pwrdn_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] dout,
    input logic       ready,
    input logic       cmd_ok,
    input logic       do_suspend,
    input logic       do_clear,
    input logic       eng_susp,
    input logic [2:0] err_flags
);
    // R9: power-down keeps the bus quiet and the ready pin high.
    a_r9_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |-> (ready && dout == 8'h00));

    // R10: no job can start while commands are still locked out.
    a_r10_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> ready);

    // R8: a hold request releases the ready pin at the next edge.
    a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
        do_suspend |=> (ready && eng_susp));

    // R4: reads while busy show a not-ready status with zero low bits.
    a_r4_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !ce_n && !oe_n) |-> (dout[7] == 1'b0 && dout[2:0] == 3'b000));

    // R7: error flags only drop on a clear command or power-down.
    a_r7_sticky_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_n && !do_clear) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .ce_n(ce_n), .oe_n(oe_n),
    .dout(dout), .ready(ready), .cmd_ok(cmd_ok), .do_suspend(do_suspend),
    .do_clear(do_clear), .eng_susp(eng_susp), .err_flags(err_flags)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int P  = 4;
    localparam int E  = 8;
    localparam int B  = 16;
    localparam int NB = 16;
    localparam int RD = 3;
    localparam int WK = 10;

    logic       clk = 1'b0;
    logic       rst_n, pwrdn_n, vpp_ok, ce_n, we_n, oe_n;
    logic [7:0] addr, din, dout, rv;
    logic       ready;
    logic [7:0] model [NB*B];
    int         nchk = 0, nerr = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.BLOCKS(NB), .BLOCK_BYTES(B), .PROG_CYC(P), .ERASE_CYC(E),
                     .READ_DLY(RD), .WAKE_DLY(WK)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .vpp_ok(vpp_ok), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .ready(ready)
    );

    function automatic [7:0] st(input bit rdy, input bit sus, input bit e, input bit w, input bit v);
        return {rdy, sus, e, w, v, 3'b000};
    endfunction

    task automatic chk(input string tag, input [7:0] act, input [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Write taken at the next rising edge; returns at the following falling edge.
    task automatic wr(input [7:0] a, input [7:0] d);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    // Combinational read within the current low phase.
    task automatic rd(input [7:0] a, output [7:0] d);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 d = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; pwrdn_n = 1'b1; vpp_ok = 1'b1;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk("R9 reset ready", {7'd0, ready}, 8'h01);
        chk("R12 idle bus", dout, 8'h00);
        rst_n = 1'b1;
        repeat (WK + 2) @(negedge clk);
        wr(8'h00, 8'h70); rd(8'h00, rv); chk("R3 status after reset", rv, 8'h80);

        // Erase every block; the first one is timed exactly.
        for (int b = 0; b < NB; b++) begin
            wr(8'(b*B), 8'h20); wr(8'(b*B + 3), 8'hD0);
            if (b == 0) begin
                repeat (E + 2*B - 1) @(negedge clk);
                chk("R2 erase busy last", {7'd0, ready}, 8'h00);
                @(negedge clk);
                chk("R2 erase done", {7'd0, ready}, 8'h01);
            end else wait_ready();
        end
        for (int i = 0; i < NB*B; i++) model[i] = 8'hFF;
        wr(8'h00, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            int a = $urandom % (NB*B);
            rd(8'(a), rv); chk("R2 erased byte", rv, 8'hFF);
        end

        // Program timing, busy reads and ignored writes.
        wr(8'h23, 8'h40); wr(8'h23, 8'hA5);
        rd(8'h23, rv); chk("R4 busy read gives status", rv, 8'h00);
        wr(8'h00, 8'hFF);
        repeat (P - 1) @(negedge clk);
        chk("R1 program busy last", {7'd0, ready}, 8'h00);
        @(negedge clk);
        chk("R1 program done", {7'd0, ready}, 8'h01);
        rd(8'h23, rv); chk("R11 busy write ignored", rv, 8'h80);
        wr(8'h00, 8'hFF); rd(8'h23, rv); chk("R1 programmed", rv, 8'hA5);
        wr(8'h23, 8'h40); wr(8'h23, 8'h5F); wait_ready();
        wr(8'h00, 8'hFF); rd(8'h23, rv); chk("R1 AND merge", rv, 8'h05);
        model[8'h23] = 8'h05;
        wr(8'h00, 8'h33); rd(8'h23, rv); chk("R11 unknown code", rv, 8'h05);
        wr(8'h00, 8'h70); rd(8'h23, rv); chk("R3 status mode", rv, 8'h80);

        // Erase setup abort and sticky errors.
        wr(8'h30, 8'h20); wr(8'h30, 8'h11);
        chk("R5 no erase started", {7'd0, ready}, 8'h01);
        rd(8'h30, rv); chk("R5 abort flags", rv, st(1,0,1,1,0));
        wr(8'h00, 8'hFF); wr(8'h00, 8'h70);
        rd(8'h30, rv); chk("R7 flags kept", rv, st(1,0,1,1,0));
        wr(8'h00, 8'h50); rd(8'h30, rv); chk("R7 flags cleared", rv, 8'h80);

        // Supply low lockout.
        vpp_ok = 1'b0;
        wr(8'h44, 8'h40); wr(8'h44, 8'h00);
        chk("R6 program locked ready", {7'd0, ready}, 8'h01);
        rd(8'h44, rv); chk("R6 program vpp flags", rv, st(1,0,0,1,1));
        wr(8'h00, 8'h50);
        wr(8'h40, 8'h20); wr(8'h40, 8'hD0);
        rd(8'h44, rv); chk("R6 erase vpp flags", rv, st(1,0,1,0,1));
        vpp_ok = 1'b1;
        wr(8'h00, 8'h50); wr(8'h00, 8'hFF);
        rd(8'h44, rv); chk("R6 array unchanged", rv, 8'hFF);

        // Erase hold and resume.
        wr(8'h50, 8'h40); wr(8'h50, 8'h3C); wait_ready(); model[8'h50] = 8'h3C;
        wr(8'h21, 8'h40); wr(8'h21, 8'h12); wait_ready();
        wr(8'h20, 8'h20); wr(8'h20, 8'hD0);
        repeat (3) @(negedge clk);
        wr(8'h00, 8'hB0);
        chk("R8 hold ready", {7'd0, ready}, 8'h01);
        rd(8'h00, rv); chk("R8 hold status", rv, st(1,1,0,0,0));
        wr(8'h00, 8'hFF); rd(8'h50, rv); chk("R8 read other block", rv, 8'h3C);
        wr(8'h00, 8'hD0);
        chk("R8 resumed busy", {7'd0, ready}, 8'h00);
        wait_ready();
        rd(8'h00, rv); chk("R8 resume status", rv, 8'h80);
        wr(8'h00, 8'hFF); rd(8'h21, rv); chk("R8 erase completed", rv, 8'hFF);
        model[8'h23] = 8'hFF;

        // Output gating.
        addr = 8'h50; ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R12 ce high", dout, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R12 oe high", dout, 8'h00);
        ce_n = 1'b1;
        @(negedge clk);

        // Power-down, then the recovery windows.
        wr(8'h00, 8'h70);
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk("R9 pd ready", {7'd0, ready}, 8'h01);
        rd(8'h50, rv); chk("R9 pd dout", rv, 8'h00);
        wr(8'h60, 8'h40); wr(8'h60, 8'h00);
        pwrdn_n = 1'b1;
        repeat (RD - 1) @(negedge clk);
        rd(8'h50, rv); chk("R10 read not yet valid", rv, 8'h00);
        @(negedge clk);
        rd(8'h50, rv); chk("R10 read valid", rv, 8'h3C);
        repeat (WK - RD - 1) @(negedge clk);
        wr(8'h00, 8'h70);
        rd(8'h50, rv); chk("R10 early command ignored", rv, 8'h3C);
        wr(8'h00, 8'h70);
        rd(8'h50, rv); chk("R10 command accepted", rv, 8'h80);
        wr(8'h00, 8'hFF); rd(8'h60, rv); chk("R9 pd write blocked", rv, 8'hFF);

        // Random program traffic with occasional supply loss.
        for (int n = 0; n < 30; n++) begin
            int  a = $urandom % (NB*B);
            int  d = $urandom % 256;
            bit  v = ($urandom % 6) != 0;
            vpp_ok = v;
            wr(8'(a), 8'h40); wr(8'(a), 8'(d));
            vpp_ok = 1'b1;
            if (v) begin
                repeat (P + 1) @(negedge clk);
                model[a] = model[a] & 8'(d);
                rd(8'h00, rv); chk("R1 random status", rv, 8'h80);
            end else begin
                rd(8'h00, rv); chk("R6 random status", rv, st(1,0,0,1,1));
                wr(8'h00, 8'h50);
            end
            wr(8'h00, 8'hFF);
            rd(8'(a), rv); chk("R1 random readback", rv, model[a]);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule